// File: doc/BRIEF.md
# DDR2 Power-Up Command Sequencer

This block issues the mode-setting part of the DDR2 SDRAM power-up procedure, from enabling the on-die DLL through leaving off-chip-driver calibration. After a one-cycle start pulse it walks through eight commands in a fixed order:

1. Extended mode write with the DLL enabled.
2. Mode write with DLL reset.
3. Precharge of all banks.
4. Two refreshes.
5. Mode write with DLL reset cleared and the operating CAS latency and burst length.
6. Extended mode write with calibration at its default setting.
7. Extended mode write with calibration exit.

Between commands it drives NOP for a programmable number of cycles. A separate lock timer starts at the DLL-reset command. Done is raised only when the last command has been issued and that timer has run out. Done then holds until reset.

Each command cycle also shows a small type code on a status output. The code identifies the kind of register write or command that is on the pins.

The state machine has these states:

- ST_IDLE waits for start, with the chip deselected.
- ST_EMR_DLL is the first extended mode write.
- ST_MRS_DLLRST is the DLL-reset mode write. It also arms the lock timer.
- ST_PRE_ALL is the precharge of all banks.
- ST_REF_A and ST_REF_B are the two refreshes.
- ST_MRS_OPER is the operating mode write.
- ST_EMR_OCD_DFLT is the calibration-default extended write.
- ST_EMR_OCD_EXIT is the calibration-exit extended write.
- ST_GAP counts out the spacing after each command, then jumps to the state latched when that command was issued.
- ST_LOCK_HOLD waits for the lock timer.
- ST_DONE is final.

The transitions are:

- ST_IDLE goes to ST_EMR_DLL on start.
- Every command state goes to ST_GAP.
- ST_GAP goes to its return state when the gap timer reaches zero.
- ST_LOCK_HOLD goes to ST_DONE when the lock timer reaches zero.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is held, the outputs are: cs_n=1, ras_n/cas_n/we_n=111, step_code=0 and done=0. ST_IDLE keeps these values until start.
- R2: After start, exactly eight commands appear, in this order: extended write, mode write, precharge-all, refresh, refresh, mode write, extended write, extended write. While each command is on the pins, step_code shows its type: 5 for an extended write, 3 for a mode write, 2 for precharge-all and 4 for refresh.
- R3: Both mode writes and extended writes use {cs_n,ras_n,cas_n,we_n}=0000. Every extended write drives ba=2'b01, and every mode write drives ba=2'b00.
- R4: Precharge-all uses 0010 with addr[10]=1. Refresh uses 0001.
- R5: Both mode writes carry the burst length in addr[2:0] and the CAS latency in addr[6:4]. The first mode write has addr[8]=1 (DLL reset); the second has addr[8]=0.
- R6: Every extended write has addr[0]=0 (DLL enabled). The calibration field addr[9:7] is 000 in the first extended write, 111 in the second and 000 in the third.
- R7: The next command starts exactly T_MRD cycles after each mode or extended write, T_RP cycles after the precharge, and T_RFC cycles after each refresh. No two commands are ever in adjacent cycles.
- R8: Every non-command cycle after start is a NOP (0111) with step_code=0.
- R9: Done rises at the later of two points: LOCK_CYC+1 cycles after the DLL-reset mode write, or T_MRD+1 cycles after the last extended write. Once high, done stays high until reset, and no command is issued while done is high.
- R10: A start pulse while the sequence runs, or after done, has no effect. No extra command appears and the timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins the sequence |
| cas_lat | input | 3 | CAS latency code placed in addr[6:4] of mode writes |
| burst_len | input | 3 | Burst length code placed in addr[2:0] of mode writes |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ROW_W | Row address and mode field bus |
| step_code | output | 3 | Type of the command currently issued, 0 on NOP |
| done | output | 1 | Sequence complete, sticky until reset |

## Verification
The properties assume that cas_lat and burst_len stay constant from start until done. The stimulus changes them only while reset is asserted. The spacing property also relies on every gap parameter being at least 2. The parameters the bench picks meet that, and the bench sweeps all 64 latency and burst code pairs.

The start pulses that must be ignored are sent at points where the sequence is known to be in a gap or in ST_DONE. Their lack of effect is then judged from the number of commands captured and from the command spacing.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_EMR_DLL,
        ST_MRS_DLLRST,
        ST_PRE_ALL,
        ST_REF_A,
        ST_REF_B,
        ST_MRS_OPER,
        ST_EMR_OCD_DFLT,
        ST_EMR_OCD_EXIT,
        ST_GAP,
        ST_LOCK_HOLD,
        ST_DONE
    } init_state_t;

    localparam logic [2:0] CODE_NONE = 3'd0;
    localparam logic [2:0] CODE_PRE  = 3'd2;
    localparam logic [2:0] CODE_MRS  = 3'd3;
    localparam logic [2:0] CODE_REF  = 3'd4;
    localparam logic [2:0] CODE_EMR  = 3'd5;

    // {ras_n, cas_n, we_n}
    localparam logic [2:0] PIN_NOP  = 3'b111;
    localparam logic [2:0] PIN_LMR  = 3'b000;
    localparam logic [2:0] PIN_PRE  = 3'b010;
    localparam logic [2:0] PIN_REF  = 3'b001;

    localparam logic [2:0] OCD_EXIT = 3'b000;
    localparam logic [2:0] OCD_DFLT = 3'b111;

endpackage

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/ddr2_init_cmd_enc.sv
module ddr2_init_cmd_enc
    import ddr2_init_pkg::*;
#(
    parameter int ROW_W = 13
) (
    input  init_state_t      st,
    input  logic [2:0]       cas_lat,
    input  logic [2:0]       burst_len,
    output logic             cs_n,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [1:0]       ba,
    output logic [ROW_W-1:0] addr,
    output logic [2:0]       step_code,
    output logic             done
);
    logic [2:0] pins;

    always_comb begin
        cs_n      = 1'b0;
        pins      = PIN_NOP;
        ba        = 2'b00;
        addr      = '0;
        step_code = CODE_NONE;
        done      = 1'b0;
        unique case (st)
            ST_IDLE: cs_n = 1'b1;
            ST_EMR_DLL: begin
                pins = PIN_LMR; ba = 2'b01; step_code = CODE_EMR;
                addr[0] = 1'b0; addr[9:7] = OCD_EXIT;
            end
            ST_MRS_DLLRST: begin
                pins = PIN_LMR; ba = 2'b00; step_code = CODE_MRS;
                addr[2:0] = burst_len; addr[6:4] = cas_lat; addr[8] = 1'b1;
            end
            ST_PRE_ALL: begin
                pins = PIN_PRE; step_code = CODE_PRE; addr[10] = 1'b1;
            end
            ST_REF_A, ST_REF_B: begin
                pins = PIN_REF; step_code = CODE_REF;
            end
            ST_MRS_OPER: begin
                pins = PIN_LMR; ba = 2'b00; step_code = CODE_MRS;
                addr[2:0] = burst_len; addr[6:4] = cas_lat; addr[8] = 1'b0;
            end
            ST_EMR_OCD_DFLT: begin
                pins = PIN_LMR; ba = 2'b01; step_code = CODE_EMR;
                addr[9:7] = OCD_DFLT;
            end
            ST_EMR_OCD_EXIT: begin
                pins = PIN_LMR; ba = 2'b01; step_code = CODE_EMR;
                addr[9:7] = OCD_EXIT;
            end
            ST_GAP, ST_LOCK_HOLD: ;
            ST_DONE: done = 1'b1;
            default: cs_n = 1'b1;
        endcase
        {ras_n, cas_n, we_n} = pins;
    end
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int ROW_W    = 13,
    parameter int T_MRD    = 2,
    parameter int T_RP     = 4,
    parameter int T_RFC    = 26,
    parameter int LOCK_CYC = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       cas_lat,
    input  logic [2:0]       burst_len,
    output logic             cs_n,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [1:0]       ba,
    output logic [ROW_W-1:0] addr,
    output logic [2:0]       step_code,
    output logic             done
);
    localparam int T_MAX  = (T_RFC > T_RP) ? ((T_RFC > T_MRD) ? T_RFC : T_MRD)
                                           : ((T_RP > T_MRD) ? T_RP : T_MRD);
    localparam int GAP_W  = $clog2(T_MAX + 1);
    localparam int LOCK_W = $clog2(LOCK_CYC + 1);
    localparam logic [GAP_W-1:0]  MRD_V  = GAP_W'(T_MRD - 2);
    localparam logic [GAP_W-1:0]  RP_V   = GAP_W'(T_RP - 2);
    localparam logic [GAP_W-1:0]  RFC_V  = GAP_W'(T_RFC - 2);
    localparam logic [LOCK_W-1:0] LOCK_V = LOCK_W'(LOCK_CYC - 1);

    init_state_t      state_q, state_d, ret_q, ret_d;
    logic             gap_load, gap_zero, lock_load, lock_zero;
    logic [GAP_W-1:0] gap_val;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ret_q   <= ST_IDLE;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        ret_d     = ret_q;
        gap_load  = 1'b0;
        gap_val   = MRD_V;
        lock_load = 1'b0;
        unique case (state_q)
            ST_IDLE:         if (start) state_d = ST_EMR_DLL;
            ST_EMR_DLL:      begin gap_load = 1'b1; ret_d = ST_MRS_DLLRST;   state_d = ST_GAP; end
            ST_MRS_DLLRST:   begin gap_load = 1'b1; lock_load = 1'b1;
                                   ret_d = ST_PRE_ALL;                       state_d = ST_GAP; end
            ST_PRE_ALL:      begin gap_load = 1'b1; gap_val = RP_V;
                                   ret_d = ST_REF_A;                         state_d = ST_GAP; end
            ST_REF_A:        begin gap_load = 1'b1; gap_val = RFC_V;
                                   ret_d = ST_REF_B;                         state_d = ST_GAP; end
            ST_REF_B:        begin gap_load = 1'b1; gap_val = RFC_V;
                                   ret_d = ST_MRS_OPER;                      state_d = ST_GAP; end
            ST_MRS_OPER:     begin gap_load = 1'b1; ret_d = ST_EMR_OCD_DFLT; state_d = ST_GAP; end
            ST_EMR_OCD_DFLT: begin gap_load = 1'b1; ret_d = ST_EMR_OCD_EXIT; state_d = ST_GAP; end
            ST_EMR_OCD_EXIT: begin gap_load = 1'b1; ret_d = ST_LOCK_HOLD;    state_d = ST_GAP; end
            ST_GAP:          if (gap_zero) state_d = ret_q;
            ST_LOCK_HOLD:    if (lock_zero) state_d = ST_DONE;
            ST_DONE:         state_d = ST_DONE;
            default:         state_d = ST_IDLE;
        endcase
    end

    ddr2_init_timer #(.CNT_W(GAP_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_val), .zero(gap_zero)
    );

    ddr2_init_timer #(.CNT_W(LOCK_W)) u_lock (
        .clk(clk), .rst_n(rst_n), .load(lock_load), .load_val(LOCK_V), .zero(lock_zero)
    );

    ddr2_init_cmd_enc #(.ROW_W(ROW_W)) u_enc (
        .st(state_q), .cas_lat(cas_lat), .burst_len(burst_len),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .step_code(step_code), .done(done)
    );
endmodule

// File: rtl/ddr2_init_chk.sv
module ddr2_init_chk #(
    parameter int ROW_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic [1:0]       ba,
    input logic [ROW_W-1:0] addr,
    input logic [2:0]       step_code,
    input logic             done
);
    logic [3:0] pins;
    logic       is_cmd;
    assign pins   = {cs_n, ras_n, cas_n, we_n};
    assign is_cmd = !cs_n && ({ras_n, cas_n, we_n} != 3'b111);

    AST_EMR_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (step_code == 3'd5) |-> (ba == 2'b01 && pins == 4'b0000));              // R3
    AST_MRS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (step_code == 3'd3) |-> (ba == 2'b00 && pins == 4'b0000));              // R3
    AST_PRE_A10: assert property (@(posedge clk) disable iff (!rst_n)
        (step_code == 3'd2) |-> (addr[10] && pins == 4'b0010));                  // R4
    AST_REF_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_code == 3'd4) |-> (pins == 4'b0001));                              // R4
    AST_NOP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !is_cmd |-> (step_code == 3'd0));                                        // R8
    AST_CMD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmd |=> !is_cmd);                                                     // R7
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);                                                          // R9
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !is_cmd);                                                       // R9
endmodule

bind ddr2_init_seq ddr2_init_chk #(.ROW_W(ROW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .step_code(step_code), .done(done)
);

// File: tb/ddr2_init_seq_test.sv
module ddr2_init_seq_test;
    localparam int ROW_W    = 13;
    localparam int T_MRD    = 2;
    localparam int T_RP     = 4;
    localparam int T_RFC    = 26;
    localparam int LOCK_CYC = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] cas_lat = 3'd0, burst_len = 3'd0;
    logic cs_n, ras_n, cas_n, we_n, done;
    logic [1:0] ba;
    logic [ROW_W-1:0] addr;
    logic [2:0] step_code;

    int checks = 0, fails = 0, cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ddr2_init_seq #(.ROW_W(ROW_W), .T_MRD(T_MRD), .T_RP(T_RP), .T_RFC(T_RFC),
                    .LOCK_CYC(LOCK_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cas_lat(cas_lat), .burst_len(burst_len),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .step_code(step_code), .done(done)
    );

    // capture of every command, sampled at the falling edge
    int ncmd, nop_bad, done_cyc, cmd_in_done;
    int c_cyc [16];
    logic [3:0] c_pins [16];
    logic [1:0] c_ba [16];
    logic [ROW_W-1:0] c_addr [16];
    logic [2:0] c_code [16];

    always @(negedge clk) begin
        if (!rst_n) begin
            ncmd = 0; nop_bad = 0; done_cyc = -1; cmd_in_done = 0;
        end else if (!cs_n && {ras_n, cas_n, we_n} != 3'b111) begin
            if (ncmd < 16) begin
                c_cyc[ncmd] = cyc; c_pins[ncmd] = {cs_n, ras_n, cas_n, we_n};
                c_ba[ncmd] = ba; c_addr[ncmd] = addr; c_code[ncmd] = step_code;
            end
            ncmd = ncmd + 1;
            if (done) cmd_in_done = cmd_in_done + 1;
        end else begin
            if (!cs_n && step_code != 3'd0) nop_bad = nop_bad + 1;
            if (done && done_cyc < 0) done_cyc = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input int k);
        case (k) 0, 6, 7: return 5; 1, 5: return 3; 2: return 2; default: return 4; endcase
    endfunction
    function automatic int exp_pins(input int k);
        case (k) 2: return 4'b0010; 3, 4: return 4'b0001; default: return 4'b0000; endcase
    endfunction
    function automatic int exp_gap(input int k);
        case (k) 2: return T_RP; 3, 4: return T_RFC; default: return T_MRD; endcase
    endfunction

    task automatic run(input int cl, input int bl);
        int m, hold, exp_done, n_before;
        @(negedge clk);
        rst_n = 1'b0; start = 1'b0; cas_lat = 3'(cl); burst_len = 3'(bl);
        repeat (3) @(negedge clk);
        chk(cs_n && {ras_n, cas_n, we_n} == 3'b111 && step_code == 0 && !done,
            "R1 reset state", {cs_n, ras_n, cas_n, we_n, done}, 5'b11110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n && !done && ncmd == 0, "R1 idle before start", ncmd, 0);
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;       // R10 mid-sequence pulse
        for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
        repeat (10) @(negedge clk);
        n_before = ncmd;
        start = 1'b1; @(negedge clk); start = 1'b0;       // R10 pulse after done
        repeat (40) @(negedge clk);

        chk(ncmd == 8, "R2 R10 command count", ncmd, 8);
        chk(ncmd == n_before, "R10 start after done", ncmd, n_before);
        if (ncmd >= 8) begin
            for (int k = 0; k < 8; k++) begin
                chk(int'(c_code[k]) == exp_code(k), "R2 step code", c_code[k], exp_code(k));
                chk(int'(c_pins[k]) == exp_pins(k), "R3 R4 command pins", c_pins[k], exp_pins(k));
                if (exp_code(k) == 5) chk(c_ba[k] == 2'b01, "R3 extended bank", c_ba[k], 1);
                if (exp_code(k) == 3) chk(c_ba[k] == 2'b00, "R3 mode bank", c_ba[k], 0);
                if (k < 7) chk(c_cyc[k+1] - c_cyc[k] == exp_gap(k), "R7 spacing",
                               c_cyc[k+1] - c_cyc[k], exp_gap(k));
            end
            chk(c_addr[2][10] == 1'b1, "R4 precharge A10", c_addr[2][10], 1);
            chk(c_addr[1][8] == 1'b1 && c_addr[5][8] == 1'b0, "R5 DLL reset bits",
                {c_addr[1][8], c_addr[5][8]}, 2);
            chk(int'(c_addr[1][6:4]) == cl && int'(c_addr[5][6:4]) == cl, "R5 CAS latency",
                c_addr[5][6:4], cl);
            chk(int'(c_addr[1][2:0]) == bl && int'(c_addr[5][2:0]) == bl, "R5 burst length",
                c_addr[5][2:0], bl);
            chk(c_addr[0][0] == 0 && c_addr[6][0] == 0 && c_addr[7][0] == 0, "R6 DLL enable",
                {c_addr[0][0], c_addr[6][0], c_addr[7][0]}, 0);
            chk(c_addr[0][9:7] == 3'b000 && c_addr[6][9:7] == 3'b111 && c_addr[7][9:7] == 3'b000,
                "R6 calibration field", {c_addr[0][9:7], c_addr[6][9:7], c_addr[7][9:7]},
                9'b000111000);
            m = c_cyc[1];
            hold = c_cyc[7] + T_MRD;
            exp_done = ((m + LOCK_CYC > hold) ? m + LOCK_CYC : hold) + 1;
            chk(done_cyc == exp_done, "R9 done timing", done_cyc - m, exp_done - m);
        end
        chk(done == 1'b1, "R9 done sticky", done, 1);
        chk(cmd_in_done == 0, "R9 quiet after done", cmd_in_done, 0);
        chk(nop_bad == 0, "R8 NOP code", nop_bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int cl = 0; cl < 8; cl++)
            for (int bl = 0; bl < 8; bl++)
                run(cl, bl);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule